// File: doc/BRIEF.md
# Dual-Queue ADC Command Sequencer

This block steps two conversion queues through a shared 64-entry table of command words. Each command word names an input channel and may ask the queue to pause once its conversion is done. Queue 1 always starts at table entry 0. Queue 2 starts at a programmable 7-bit begin pointer. When a queue is triggered, the sequencer reads its command words in order. For each one it sends a one-cycle start request, with the channel number, to an external converter. It then waits for the converter's done pulse before it looks at the next word.

A queue stops for one of three reasons. The first is a word that holds the reserved channel code. The second is the end of the table. The third applies only to queue 1: its walk reaches queue 2's begin pointer. Each of these stop conditions has its own rule for whether the current entry is converted. A stop condition also overrides a pause request made by the command word just before it.

For each queue the block keeps a sticky completion flag and a sticky pause flag, both cleared by write-one-to-clear inputs. It also reports each queue's status: idle, active or paused. A paused queue continues from the entry after the paused one when it is triggered again. The table is loaded through a simple write port.

Top module: `adc_cmd_seq`

## Requirements
- R1: A table word is 7 bits: bits 5:0 hold the channel and bit 6 is the pause request. A word whose channel is 63 ends the queue that reads it. That word is not converted, the queue's completion flag is set and the queue returns to idle.
- R2: A trigger on queue 1 (trig bit 0) walks the table from entry 0 upward. Each word is converted in order with exactly one single-cycle conv_start pulse carrying its channel. The next word is evaluated only after conv_done has been received.
- R3: A trigger on queue 2 (trig bit 1) starts at the begin pointer. With the begin pointer at 63, entry 63 is converted, then the queue completes at the table end and goes idle.
- R4: With the begin pointer in the range 64 to 127, a queue 2 trigger completes at once: no conversion, completion flag bit 1 set, queue 2 idle.
- R5: When queue 1 reaches the entry that the begin pointer selects, that entry is not converted and queue 1 completes. With a begin pointer of 0, a queue 1 trigger completes with no conversion.
- R6: When stop conditions coincide (for example, the begin pointer is 0 and entry 0 holds code 63), the result is identical to a single stop condition: one completion, no conversion, queue idle.
- R7: A word with its pause bit set, followed by a word that is not a stop condition, is converted normally. After that conversion the pause flag is set and the status becomes paused. The next trigger converts the following entry first.
- R8: A paused word that is followed by a stop condition is converted, and then sets both the pause flag and the completion flag. The status ends idle, not paused. This holds for a following code-63 word, for a pause in entry 63, and for a queue 1 pause just before the begin pointer.
- R9: A trigger is ignored while any queue is active. If both queues are triggered in the same cycle while the block is idle, queue 1 runs and the queue 2 trigger is dropped.
- R10: Completion and pause flags stay set until a 1 is written to the matching bit of cmpl_clr or pause_clr. Bit 0 belongs to queue 1 and bit 1 to queue 2. A set in the same cycle as a clear wins.
- R11: Status code 00 means idle, 01 means active and 10 means paused. After reset both statuses are 00, all flags are 0 and conv_start is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tbl_we | input | 1 | Table write enable |
| tbl_waddr | input | 6 | Table write address |
| tbl_wdata | input | 7 | Table word: pause bit 6, channel 5:0 |
| bq2_ptr | input | 7 | Queue 2 begin pointer |
| trig | input | 2 | Trigger pulses; bit 0 queue 1, bit 1 queue 2 |
| conv_start | output | 1 | Single-cycle conversion request |
| conv_chan | output | 6 | Channel of the requested conversion |
| conv_done | input | 1 | Converter finished pulse |
| cmpl_clr | input | 2 | Write-one-to-clear for completion flags |
| pause_clr | input | 2 | Write-one-to-clear for pause flags |
| cmpl_flag | output | 2 | Sticky completion flags |
| pause_flag | output | 2 | Sticky pause flags |
| q1_status | output | 2 | Queue 1 status |
| q2_status | output | 2 | Queue 2 status |

## Verification
The hardest situation to reach from the ports is a pause request that meets a stop condition on the very next entry. The pause must be reported while the queue still ends idle, and this has to be shown for all three kinds of stop condition. The bench loads short tables that place a paused word directly before a code-63 word, inside entry 63, or directly before the begin pointer. For each case it checks the converted channel list, both flags and the status once the queue settles. A separate pause-and-resume run confirms that a pause with no following stop condition does leave the queue paused and that the next trigger resumes at the next entry.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  typedef enum logic [1:0] {
    QS_IDLE   = 2'b00,
    QS_ACTIVE = 2'b01,
    QS_PAUSED = 2'b10
  } qstat_e;

  typedef enum logic [1:0] {
    SQ_IDLE  = 2'b00,
    SQ_FETCH = 2'b01,
    SQ_WAIT  = 2'b10
  } sq_state_e;

endpackage

// File: rtl/ccw_table.sv
module ccw_table #(
  parameter int CH_W  = 6,
  localparam int WRD_W = CH_W + 1,
  localparam int DEPTH = 2 ** CH_W
) (
  input  logic             clk,
  input  logic             we,
  input  logic [CH_W-1:0]  waddr,
  input  logic [WRD_W-1:0] wdata,
  input  logic [CH_W-1:0]  raddr,
  output logic [CH_W-1:0]  rd_chan,
  output logic             rd_pause
);
  logic [WRD_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      mem[waddr] <= wdata;
    end
  end

  assign rd_chan  = mem[raddr][CH_W-1:0];
  assign rd_pause = mem[raddr][CH_W];
endmodule

// File: rtl/eoq_detect.sv
module eoq_detect #(
  parameter int CH_W  = 6,
  localparam int PTR_W = CH_W + 1
) (
  input  logic [PTR_W-1:0] ptr,
  input  logic             is_q1,
  input  logic [PTR_W-1:0] bq2,
  input  logic [CH_W-1:0]  rd_chan,
  output logic             eoq
);
  logic beyond, code_hit, bq_hit;

  always_comb begin
    beyond   = ptr[CH_W];
    code_hit = (~beyond) & (&rd_chan);
    bq_hit   = is_q1 & (ptr == bq2);
    eoq      = beyond | code_hit | bq_hit;
  end
endmodule

// File: rtl/seq_ctrl.sv
module seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int CH_W  = 6,
  localparam int PTR_W = CH_W + 1,
  localparam logic [PTR_W-1:0] LAST = PTR_W'((2 ** CH_W) - 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       trig,
  input  logic [PTR_W-1:0] bq2,
  input  logic             eoq,
  input  logic             rd_pause,
  input  logic             conv_done,
  output logic             conv_start,
  output logic [PTR_W-1:0] cur_ptr,
  output logic             cur_is_q1,
  output logic             busy,
  output logic             in_fetch,
  output logic [1:0]       q_paused,
  output logic [1:0]       set_cmpl,
  output logic [1:0]       set_pause
);
  sq_state_e        state, state_n;
  logic             cq, cq_n;
  logic             pend, pend_n;
  logic [1:0]       paused_n;
  logic [PTR_W-1:0] ptr_q [2];
  logic [PTR_W-1:0] ptr_n [2];
  logic             acc, acc_q;

  assign cur_ptr   = ptr_q[cq];
  assign cur_is_q1 = ~cq;
  assign busy      = (state != SQ_IDLE);
  assign in_fetch  = (state == SQ_FETCH);

  always_comb begin
    state_n    = state;
    cq_n       = cq;
    pend_n     = pend;
    paused_n   = q_paused;
    ptr_n      = ptr_q;
    set_cmpl   = 2'b00;
    set_pause  = 2'b00;
    conv_start = 1'b0;
    acc        = trig[0] | trig[1];
    acc_q      = ~trig[0];
    unique case (state)
      SQ_IDLE: begin
        if (acc) begin
          cq_n    = acc_q;
          pend_n  = 1'b0;
          state_n = SQ_FETCH;
          if (!q_paused[acc_q]) begin
            ptr_n[acc_q] = acc_q ? bq2 : '0;
          end
          paused_n[acc_q] = 1'b0;
        end
      end
      SQ_FETCH: begin
        if (eoq) begin
          set_cmpl[cq] = 1'b1;
          state_n      = SQ_IDLE;
        end else if (pend) begin
          paused_n[cq] = 1'b1;
          state_n      = SQ_IDLE;
        end else begin
          conv_start = 1'b1;
          state_n    = SQ_WAIT;
        end
      end
      SQ_WAIT: begin
        if (conv_done) begin
          if (rd_pause) begin
            set_pause[cq] = 1'b1;
            pend_n        = 1'b1;
          end
          if (cur_ptr == LAST) begin
            set_cmpl[cq] = 1'b1;
            state_n      = SQ_IDLE;
          end else begin
            ptr_n[cq] = cur_ptr + 1'b1;
            state_n   = SQ_FETCH;
          end
        end
      end
      default: state_n = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= SQ_IDLE;
      cq       <= 1'b0;
      pend     <= 1'b0;
      q_paused <= 2'b00;
      ptr_q[0] <= '0;
      ptr_q[1] <= '0;
    end else begin
      state    <= state_n;
      cq       <= cq_n;
      pend     <= pend_n;
      q_paused <= paused_n;
      ptr_q[0] <= ptr_n[0];
      ptr_q[1] <= ptr_n[1];
    end
  end
endmodule

// File: rtl/flag_bank.sv
module flag_bank #(
  parameter int NQ = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NQ-1:0] set_cmpl,
  input  logic [NQ-1:0] clr_cmpl,
  input  logic [NQ-1:0] set_pause,
  input  logic [NQ-1:0] clr_pause,
  output logic [NQ-1:0] cmpl,
  output logic [NQ-1:0] pause
);
  for (genvar g = 0; g < NQ; g++) begin : g_q
    logic c_n, p_n;
    always_comb begin
      c_n = set_cmpl[g]  | (cmpl[g]  & ~clr_cmpl[g]);
      p_n = set_pause[g] | (pause[g] & ~clr_pause[g]);
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cmpl[g]  <= 1'b0;
        pause[g] <= 1'b0;
      end else begin
        cmpl[g]  <= c_n;
        pause[g] <= p_n;
      end
    end
  end
endmodule

// File: rtl/adc_cmd_seq.sv
module adc_cmd_seq
  import adc_seq_pkg::*;
#(
  parameter int CH_W  = 6,
  localparam int PTR_W = CH_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tbl_we,
  input  logic [CH_W-1:0]  tbl_waddr,
  input  logic [CH_W:0]    tbl_wdata,
  input  logic [PTR_W-1:0] bq2_ptr,
  input  logic [1:0]       trig,
  output logic             conv_start,
  output logic [CH_W-1:0]  conv_chan,
  input  logic             conv_done,
  input  logic [1:0]       cmpl_clr,
  input  logic [1:0]       pause_clr,
  output logic [1:0]       cmpl_flag,
  output logic [1:0]       pause_flag,
  output logic [1:0]       q1_status,
  output logic [1:0]       q2_status
);
  logic [PTR_W-1:0] cur_ptr;
  logic             cur_is_q1, busy, in_fetch, eoq, rd_pause;
  logic [CH_W-1:0]  rd_chan;
  logic [1:0]       q_paused, set_cmpl, set_pause;
  qstat_e           qstat [2];

  ccw_table #(.CH_W(CH_W)) u_tbl (
    .clk(clk), .we(tbl_we), .waddr(tbl_waddr), .wdata(tbl_wdata),
    .raddr(cur_ptr[CH_W-1:0]), .rd_chan(rd_chan), .rd_pause(rd_pause)
  );

  eoq_detect #(.CH_W(CH_W)) u_eoq (
    .ptr(cur_ptr), .is_q1(cur_is_q1), .bq2(bq2_ptr),
    .rd_chan(rd_chan), .eoq(eoq)
  );

  seq_ctrl #(.CH_W(CH_W)) u_ctl (
    .clk(clk), .rst_n(rst_n), .trig(trig), .bq2(bq2_ptr), .eoq(eoq),
    .rd_pause(rd_pause), .conv_done(conv_done), .conv_start(conv_start),
    .cur_ptr(cur_ptr), .cur_is_q1(cur_is_q1), .busy(busy),
    .in_fetch(in_fetch), .q_paused(q_paused), .set_cmpl(set_cmpl),
    .set_pause(set_pause)
  );

  flag_bank #(.NQ(2)) u_flg (
    .clk(clk), .rst_n(rst_n), .set_cmpl(set_cmpl), .clr_cmpl(cmpl_clr),
    .set_pause(set_pause), .clr_pause(pause_clr),
    .cmpl(cmpl_flag), .pause(pause_flag)
  );

  assign conv_chan = rd_chan;

  for (genvar g = 0; g < 2; g++) begin : g_st
    always_comb begin
      if (busy && (cur_is_q1 == (g == 0))) qstat[g] = QS_ACTIVE;
      else if (q_paused[g])                qstat[g] = QS_PAUSED;
      else                                 qstat[g] = QS_IDLE;
    end
  end

  assign q1_status = qstat[0];
  assign q2_status = qstat[1];
endmodule

// File: rtl/adc_cmd_seq_chk.sv
module adc_cmd_seq_chk #(
  parameter int CH_W = 6
) (
  input logic            clk,
  input logic            rst_n,
  input logic            conv_start,
  input logic [CH_W-1:0] conv_chan,
  input logic            in_fetch,
  input logic            eoq,
  input logic [1:0]      cmpl_flag,
  input logic [1:0]      cmpl_clr,
  input logic [1:0]      q1_status,
  input logic [1:0]      q2_status
);
  AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start); // R2
  AST_NO_CODE_CONV: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> (conv_chan != '1)); // R1
  AST_EOQ_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
    (in_fetch && eoq) |-> !conv_start); // R4
  AST_CMPL_IDLE_Q1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmpl_flag[0]) |-> (q1_status == 2'b00)); // R8
  AST_CMPL_IDLE_Q2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmpl_flag[1]) |-> (q2_status == 2'b00)); // R8
  AST_STATUS_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    (q1_status != 2'b11) && (q2_status != 2'b11)); // R11
  AST_ONE_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !((q1_status == 2'b01) && (q2_status == 2'b01))); // R9
  AST_CMPL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (cmpl_flag[0] && !cmpl_clr[0]) |=> cmpl_flag[0]); // R10
endmodule

bind adc_cmd_seq adc_cmd_seq_chk #(.CH_W(CH_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .conv_start(conv_start), .conv_chan(conv_chan),
  .in_fetch(in_fetch), .eoq(eoq), .cmpl_flag(cmpl_flag), .cmpl_clr(cmpl_clr),
  .q1_status(q1_status), .q2_status(q2_status)
);

// File: tb/adc_cmd_seq_bench.sv
module adc_cmd_seq_bench;
  localparam int CLK_P = 10;

  logic       clk, rst_n, tbl_we, conv_start, conv_done;
  logic [5:0] tbl_waddr, conv_chan;
  logic [6:0] tbl_wdata, bq2_ptr;
  logic [1:0] trig, cmpl_clr, pause_clr, cmpl_flag, pause_flag, q1_status, q2_status;

  int total = 0, bad = 0, n_log = 0, dly = 0;
  int log_ch [64];

  adc_cmd_seq u_adc_cmd_seq (.*);

  initial begin clk = 0; forever #(CLK_P/2) clk = ~clk; end

  initial begin
    conv_done = 0;
    forever begin
      @(negedge clk);
      conv_done = 0;
      if (dly > 0) begin dly--; if (dly == 0) conv_done = 1; end
      if (conv_start) begin
        if (n_log < 64) log_ch[n_log] = int'(conv_chan);
        n_log++;
        dly = 2;
      end
    end
  end

  task automatic chk(string req, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic wr(int a, int ch, bit p);
    @(negedge clk);
    tbl_we = 1; tbl_waddr = 6'(a); tbl_wdata = {p, 6'(ch)};
    @(negedge clk);
    tbl_we = 0;
  endtask

  task automatic clear_all();
    @(negedge clk); cmpl_clr = 2'b11; pause_clr = 2'b11;
    @(negedge clk); cmpl_clr = 0; pause_clr = 0;
    n_log = 0;
  endtask

  task automatic run_q(int q);
    int guard = 0;
    @(negedge clk); trig[q] = 1;
    @(negedge clk); trig = 0;
    while (((q == 0) ? q1_status : q2_status) == 2'b01 && guard < 2000) begin
      @(negedge clk); guard++;
    end
  endtask

  task automatic chk_log(string req, int n, int e0, int e1, int e2, int e3);
    int ex [4];
    ex = '{e0, e1, e2, e3};
    chk(req, "conversion count", n_log, n);
    for (int i = 0; i < n && i < 4; i++) chk(req, "channel", log_ch[i], ex[i]);
  endtask

  task automatic t_reset();
    chk("R11", "q1 status", q1_status, 0);
    chk("R11", "q2 status", q2_status, 0);
    chk("R11", "flags", {cmpl_flag, pause_flag}, 0);
    chk("R11", "conv_start", conv_start, 0);
  endtask

  task automatic t_basic();
    clear_all(); bq2_ptr = 100;
    wr(0, 5, 0); wr(1, 9, 0); wr(2, 12, 0); wr(3, 20, 0); wr(4, 63, 0);
    run_q(0);
    chk_log("R2", 4, 5, 9, 12, 20);
    chk("R1", "cmpl1", cmpl_flag[0], 1);
    chk("R1", "q1 idle", q1_status, 0);
    chk("R1", "cmpl2", cmpl_flag[1], 0);
  endtask

  task automatic t_clear();
    @(negedge clk); cmpl_clr = 2'b01;
    @(negedge clk); cmpl_clr = 0;
    chk("R10", "cmpl1 cleared", cmpl_flag[0], 0);
    @(negedge clk); @(negedge clk);
    chk("R10", "still clear", cmpl_flag, 0);
  endtask

  task automatic t_q2_last();
    clear_all(); bq2_ptr = 63; wr(63, 33, 0);
    run_q(1);
    chk_log("R3", 1, 33, 0, 0, 0);
    chk("R3", "cmpl2", cmpl_flag[1], 1);
    chk("R3", "q2 idle", q2_status, 0);
  endtask

  task automatic t_q2_beyond();
    clear_all(); bq2_ptr = 100;
    run_q(1);
    chk("R4", "no conversion", n_log, 0);
    chk("R4", "cmpl2", cmpl_flag[1], 1);
    chk("R4", "q2 idle", q2_status, 0);
  endtask

  task automatic t_q1_bq0();
    clear_all(); bq2_ptr = 0;
    run_q(0);
    chk("R5", "no conversion", n_log, 0);
    chk("R5", "cmpl1", cmpl_flag[0], 1);
    clear_all(); bq2_ptr = 2;
    run_q(0);
    chk_log("R5", 2, 5, 9, 0, 0);
    chk("R5", "cmpl1 at bq2", cmpl_flag[0], 1);
  endtask

  task automatic t_multi();
    clear_all(); bq2_ptr = 0; wr(0, 63, 0);
    run_q(0);
    chk("R6", "no conversion", n_log, 0);
    chk("R6", "flags", {cmpl_flag, pause_flag}, 4'b0100);
    chk("R6", "q1 idle", q1_status, 0);
  endtask

  task automatic t_pause_resume();
    clear_all(); bq2_ptr = 100;
    wr(0, 1, 0); wr(1, 2, 1); wr(2, 3, 0); wr(3, 63, 0);
    run_q(0);
    chk_log("R7", 2, 1, 2, 0, 0);
    chk("R7", "pause1", pause_flag[0], 1);
    chk("R7", "cmpl1", cmpl_flag[0], 0);
    chk("R7", "q1 paused", q1_status, 2);
    n_log = 0;
    run_q(0);
    chk_log("R7", 1, 3, 0, 0, 0);
    chk("R7", "cmpl1 after resume", cmpl_flag[0], 1);
    chk("R7", "q1 idle", q1_status, 0);
  endtask

  task automatic t_pause_eoq();
    clear_all(); bq2_ptr = 100; wr(0, 4, 1); wr(1, 63, 0);
    run_q(0);
    chk_log("R8", 1, 4, 0, 0, 0);
    chk("R8", "code: flags", {cmpl_flag[0], pause_flag[0]}, 2'b11);
    chk("R8", "code: q1 idle", q1_status, 0);
    clear_all(); bq2_ptr = 1; wr(1, 8, 0);
    run_q(0);
    chk_log("R8", 1, 4, 0, 0, 0);
    chk("R8", "bq2: flags", {cmpl_flag[0], pause_flag[0]}, 2'b11);
    chk("R8", "bq2: q1 idle", q1_status, 0);
    clear_all(); bq2_ptr = 63; wr(63, 33, 1);
    run_q(1);
    chk_log("R8", 1, 33, 0, 0, 0);
    chk("R8", "end: flags", {cmpl_flag[1], pause_flag[1]}, 2'b11);
    chk("R8", "end: q2 idle", q2_status, 0);
  endtask

  task automatic t_ignore();
    int guard = 0;
    clear_all(); bq2_ptr = 100;
    wr(0, 5, 0); wr(1, 9, 0); wr(2, 12, 0); wr(3, 20, 0); wr(4, 63, 0);
    @(negedge clk); trig = 2'b11;
    @(negedge clk); trig = 0;
    chk("R9", "q2 dropped", q2_status, 0);
    @(negedge clk); @(negedge clk); trig = 2'b11;
    @(negedge clk); trig = 0;
    while (q1_status == 2'b01 && guard < 2000) begin @(negedge clk); guard++; end
    chk_log("R9", 4, 5, 9, 12, 20);
    chk("R9", "cmpl", cmpl_flag, 2'b01);
    chk("R9", "q2 idle", q2_status, 0);
  endtask

  initial begin
    #(CLK_P * 150000);
    bad++; total++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 0; tbl_we = 0; tbl_waddr = 0; tbl_wdata = 0; bq2_ptr = 100;
    trig = 0; cmpl_clr = 0; pause_clr = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    for (int i = 0; i < 64; i++) wr(i, i % 40, 0);
    t_basic();
    t_clear();
    t_q2_last();
    t_q2_beyond();
    t_q1_bq0();
    t_multi();
    wr(0, 5, 0);
    t_pause_resume();
    t_pause_eoq();
    t_ignore();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule